// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block gathers up to 32 request lines from peripherals and external pins and drives three signals towards a processor: a normal interrupt, a fast interrupt and a wake-up. Each source has its own enable, its own trigger type, a priority from 0 to 7 and a 32-bit handler address. Source 0 feeds the fast interrupt directly. Sources 1 and up compete in a priority arbiter. Any of them can also be forced onto the fast output.

Software reads the vector register and gets the handler address of the winning source. That read acknowledges the source: its priority goes onto an internal stack of active levels, and its edge flag is cleared. An end-of-service write pops the stack. Only a request of strictly higher priority than the top of the stack raises the normal interrupt again, so handlers nest. A protect setting lets a debugger read the vector without disturbing state. A general mask silences both interrupt outputs but keeps the wake-up signal alive.

Top module: `vnic_top`

## Requirements
- R1: Register map. The mode register of source i is at 0x00+i, with the priority in bits [2:0], the edge select in bit 5 and the invert select in bit 6. The vector register of source i is at 0x20+i. A read of the vector register 0x40 returns the vector of the winning source. The winner is the pending, enabled, unforced source numbered 1 or above that has the highest priority. Among equal priorities the lowest source number wins.
- R2: Source 0 takes no part in arbitration. When it is pending and enabled it drives the fast output. A read of 0x41 returns the vector of source 0 and clears its edge flag.
- R3: Trigger type. Edge=0 gives a level source and edge=1 gives an edge source. Invert=1 selects low level or falling edge. The invert bit acts only on sources marked external by the EXT_MASK parameter. An internal source treats it as 0.
- R4: An edge source latches its flag at the first clock edge after the active transition. The flag stays set until the source is acknowledged or bits are written to the clear register 0x44.
- R5: The normal output is high only when the stack is empty or the winner's priority is strictly above the priority on top of the stack.
- R6: With protect off, a read of 0x40 that finds a winner pushes the winner's priority and clears the winner's edge flag. A push into a full stack is ignored.
- R7: A write to 0x45 pops the stack and restores the previous level. A pop on an empty stack leaves it empty. Register 0x4B reads back the top priority in bits [2:0] and the depth in bits [11:8].
- R8: Protect is bit 0 of control register 0x49. With protect on, a read of 0x40 has no side effect, and a write to 0x40 performs the push and the clear instead.
- R9: When no source qualifies at the moment 0x40 is accessed, the read returns the value held in 0x46 and nothing is pushed.
- R10: Writing 1s to 0x47 forces sources and writing 1s to 0x48 releases them. A forced source drives the fast output and is kept out of the normal arbitration. Its edge flag is not cleared by either vector read.
- R11: General mask is bit 1 of 0x49. While it is set, both interrupt outputs stay low. The wake output is high whenever any enabled source is pending, whatever the mask.
- R12: Writing 1s to 0x42 enables sources and writing 1s to 0x43 disables them; 0x42 reads back the enable set. A disabled source affects no output. After reset all sources are disabled, the stack is empty and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NSRC | Interrupt request lines, synchronous to clk |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read side effects occur at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the address |
| cpu_irq | output | 1 | Normal interrupt request to the processor |
| cpu_fiq | output | 1 | Fast interrupt request to the processor |
| cpu_wake | output | 1 | Wake-up indication, unaffected by the general mask |

## Verification
A corrupted level stack shows up one cycle after the acknowledging read, in two places. The normal output fails to drop for a request at the same level, and the level register reads back the wrong depth or top. The bench reads both after each push and pop. A wrong edge flag shows as a normal or fast output that stays high after an acknowledge, or that never rises after a one-cycle pulse. A wrong tie-break or a wrong forcing rule shows at once as a wrong vector from a read.

// File: rtl/vnic_pkg.sv
`timescale 1ns/1ps
package vnic_pkg;
   // register addresses
   localparam int MODE_BASE   = 'h00;
   localparam int VEC_BASE    = 'h20;
   localparam int REG_IVEC    = 'h40;
   localparam int REG_FVEC    = 'h41;
   localparam int REG_EN_SET  = 'h42;
   localparam int REG_EN_CLR  = 'h43;
   localparam int REG_FLAG_CLR = 'h44;
   localparam int REG_EOS     = 'h45;
   localparam int REG_SPUR    = 'h46;
   localparam int REG_FRC_SET = 'h47;
   localparam int REG_FRC_CLR = 'h48;
   localparam int REG_CTRL    = 'h49;
   localparam int REG_RAW     = 'h4A;
   localparam int REG_LEVEL   = 'h4B;
   // field positions
   localparam int MODE_EDGE_BIT = 5;
   localparam int MODE_INV_BIT  = 6;
   localparam int CTRL_PROT_BIT = 0;
   localparam int CTRL_MASK_BIT = 1;
   localparam int LEVEL_CNT_LSB = 8;
endpackage

// File: rtl/vnic_src_cond.sv
`timescale 1ns/1ps
module vnic_src_cond #(
   parameter int NSRC = 32,
   parameter logic [NSRC-1:0] EXT_MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] lines,
   input  logic [NSRC-1:0] edge_sel,
   input  logic [NSRC-1:0] inv_sel,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] pend
);
   logic [NSRC-1:0] prev_q;
   logic [NSRC-1:0] flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic inv_eff, act_now, act_old;
      assign inv_eff = inv_sel[i] & EXT_MASK[i];
      assign act_now = lines[i] ^ inv_eff;
      assign act_old = prev_q[i] ^ inv_eff;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               flag_q[i] <= 1'b0;
         else if (edge_sel[i] && act_now && !act_old) flag_q[i] <= 1'b1;
         else if (clr[i])                          flag_q[i] <= 1'b0;
      end

      assign pend[i] = edge_sel[i] ? flag_q[i] : act_now;

      // R4
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr[i]) |=> flag_q[i]);
   end
endmodule

// File: rtl/vnic_arbiter.sv
`timescale 1ns/1ps
module vnic_arbiter #(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 3,
   localparam int IDX_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]             cand,
   input  logic [NSRC-1:0][PRIO_W-1:0] prio,
   output logic                        win_valid,
   output logic [IDX_W-1:0]            win_id,
   output logic [PRIO_W-1:0]           win_prio
);
   // descending scan with >= lets the lower number take a tie
   always_comb begin
      win_valid = 1'b0;
      win_id    = '0;
      win_prio  = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (cand[i] && (!win_valid || prio[i] >= win_prio)) begin
            win_valid = 1'b1;
            win_id    = IDX_W'(i);
            win_prio  = prio[i];
         end
      end
   end
endmodule

// File: rtl/vnic_prio_stack.sv
`timescale 1ns/1ps
module vnic_prio_stack #(
   parameter int DEPTH  = 8,
   parameter int PRIO_W = 3,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [PRIO_W-1:0] push_prio,
   output logic [PRIO_W-1:0] top,
   output logic [CNT_W-1:0]  cnt,
   output logic              empty,
   output logic              full
);
   logic [PRIO_W-1:0] mem_q [DEPTH];

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (push && !full)    cnt <= cnt + 1'b1;
      else if (pop && !empty)    cnt <= cnt - 1'b1;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++)
         if (push && !full && cnt == CNT_W'(i)) mem_q[i] <= push_prio;
   end

   always_comb begin
      top = '0;
      for (int i = 0; i < DEPTH; i++)
         if (cnt == CNT_W'(i + 1)) top = mem_q[i];
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R7
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && empty) |=> (cnt == '0));
   // R7
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !empty) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/vnic_top.sv
`timescale 1ns/1ps
module vnic_top
   import vnic_pkg::*;
#(
   parameter int NSRC   = 32,
   parameter int PRIO_W = 3,
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter logic [NSRC-1:0] EXT_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cpu_irq,
   output logic              cpu_fiq,
   output logic              cpu_wake
);
   localparam int IDX_W = $clog2(NSRC);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [ADDR_W-1:0] A_IVEC = ADDR_W'(REG_IVEC);
   localparam logic [ADDR_W-1:0] A_FVEC = ADDR_W'(REG_FVEC);
   localparam logic [ADDR_W-1:0] A_ENS  = ADDR_W'(REG_EN_SET);
   localparam logic [ADDR_W-1:0] A_ENC  = ADDR_W'(REG_EN_CLR);
   localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(REG_FLAG_CLR);
   localparam logic [ADDR_W-1:0] A_EOS  = ADDR_W'(REG_EOS);
   localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(REG_SPUR);
   localparam logic [ADDR_W-1:0] A_FRS  = ADDR_W'(REG_FRC_SET);
   localparam logic [ADDR_W-1:0] A_FRC  = ADDR_W'(REG_FRC_CLR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(REG_RAW);
   localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(REG_LEVEL);

   if (NSRC < 2 || NSRC > 32) begin : g_bad_nsrc
      $error("NSRC must lie in 2..32");
   end
   if (PRIO_W < 1 || PRIO_W > MODE_EDGE_BIT) begin : g_bad_prio
      $error("PRIO_W must fit below the edge bit");
   end
   if (DEPTH < (1 << PRIO_W)) begin : g_bad_depth
      $error("DEPTH must hold one entry per priority level");
   end
   if (ADDR_W < 7 || DATA_W < NSRC || DATA_W < LEVEL_CNT_LSB + CNT_W) begin : g_bad_bus
      $error("bus widths too narrow for the register map");
   end

   // configuration state
   logic [NSRC-1:0]             en_q, frc_q, edge_q, inv_q;
   logic [NSRC-1:0][PRIO_W-1:0] prio_q;
   logic [DATA_W-1:0]           vec_q [NSRC];
   logic [DATA_W-1:0]           spur_q;
   logic                        prot_q, gmask_q;

   // datapath
   logic [NSRC-1:0]   pend_raw, pend_en, cand, clr;
   logic              win_valid, eligible;
   logic [IDX_W-1:0]  win_id;
   logic [PRIO_W-1:0] win_prio, stk_top;
   logic [CNT_W-1:0]  stk_cnt;
   logic              stk_empty, stk_full, stk_push, stk_pop;
   logic              in_mode, in_vec, ivec_rd, ack_go, fvec_rd;
   logic [IDX_W-1:0]  idx;

   assign idx     = bus_addr[IDX_W-1:0];
   assign in_mode = (bus_addr < ADDR_W'(MODE_BASE + NSRC));
   assign in_vec  = (bus_addr >= ADDR_W'(VEC_BASE)) && (bus_addr < ADDR_W'(VEC_BASE + NSRC));
   assign ivec_rd = bus_rd && (bus_addr == A_IVEC);
   assign fvec_rd = bus_rd && (bus_addr == A_FVEC);
   assign ack_go  = prot_q ? (bus_wr && bus_addr == A_IVEC) : ivec_rd;

   vnic_src_cond #(.NSRC(NSRC), .EXT_MASK(EXT_MASK)) u_cond (
      .clk(clk), .rst_n(rst_n), .lines(irq_in), .edge_sel(edge_q),
      .inv_sel(inv_q), .clr(clr), .pend(pend_raw));

   assign pend_en = pend_raw & en_q;
   assign cand    = pend_en & ~frc_q & ~NSRC'(1);

   vnic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
      .cand(cand), .prio(prio_q), .win_valid(win_valid),
      .win_id(win_id), .win_prio(win_prio));

   assign eligible = win_valid && (stk_empty || win_prio > stk_top);
   assign stk_push = ack_go && eligible;
   assign stk_pop  = bus_wr && (bus_addr == A_EOS);

   vnic_prio_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
      .push_prio(win_prio), .top(stk_top), .cnt(stk_cnt),
      .empty(stk_empty), .full(stk_full));

   always_comb begin
      clr = '0;
      if (bus_wr && bus_addr == A_FCLR) clr = bus_wdata[NSRC-1:0];
      if (stk_push) clr = clr | (NSRC'(1) << win_id);
      if (fvec_rd)  clr = clr | NSRC'(1);
   end

   assign cpu_irq  = eligible && !gmask_q;
   assign cpu_fiq  = (pend_en[0] || |(pend_en & frc_q)) && !gmask_q;
   assign cpu_wake = |pend_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;  frc_q <= '0;  edge_q <= '0;  inv_q <= '0;
         prio_q <= '0;  spur_q <= '0;  prot_q <= 1'b0;  gmask_q <= 1'b0;
      end else if (bus_wr) begin
         if (in_mode) begin
            for (int i = 0; i < NSRC; i++)
               if (idx == IDX_W'(i)) begin
                  prio_q[i] <= bus_wdata[PRIO_W-1:0];
                  edge_q[i] <= bus_wdata[MODE_EDGE_BIT];
                  inv_q[i]  <= bus_wdata[MODE_INV_BIT];
               end
         end
         case (bus_addr)
            A_ENS:  en_q    <= en_q | bus_wdata[NSRC-1:0];
            A_ENC:  en_q    <= en_q & ~bus_wdata[NSRC-1:0];
            A_FRS:  frc_q   <= frc_q | bus_wdata[NSRC-1:0];
            A_FRC:  frc_q   <= frc_q & ~bus_wdata[NSRC-1:0];
            A_SPUR: spur_q  <= bus_wdata;
            A_CTRL: begin
               prot_q  <= bus_wdata[CTRL_PROT_BIT];
               gmask_q <= bus_wdata[CTRL_MASK_BIT];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NSRC; i++)
         if (bus_wr && in_vec && idx == IDX_W'(i)) vec_q[i] <= bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      if (in_mode) begin
         bus_rdata[PRIO_W-1:0]    = prio_q[idx];
         bus_rdata[MODE_EDGE_BIT] = edge_q[idx];
         bus_rdata[MODE_INV_BIT]  = inv_q[idx];
      end else if (in_vec) begin
         bus_rdata = vec_q[idx];
      end else begin
         case (bus_addr)
            A_IVEC: bus_rdata = eligible ? vec_q[win_id] : spur_q;
            A_FVEC: bus_rdata = vec_q[0];
            A_ENS:  bus_rdata[NSRC-1:0] = en_q;
            A_FRS:  bus_rdata[NSRC-1:0] = frc_q;
            A_SPUR: bus_rdata = spur_q;
            A_CTRL: begin
               bus_rdata[CTRL_PROT_BIT] = prot_q;
               bus_rdata[CTRL_MASK_BIT] = gmask_q;
            end
            A_RAW:  bus_rdata[NSRC-1:0] = pend_raw;
            A_LVL:  begin
               bus_rdata[PRIO_W-1:0] = stk_top;
               bus_rdata[LEVEL_CNT_LSB +: CNT_W] = stk_cnt;
            end
            default: ;
         endcase
      end
   end

   // R11
   mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gmask_q |-> (!cpu_irq && !cpu_fiq));
   // R12
   all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> (!cpu_irq && !cpu_fiq && !cpu_wake));
   // R6
   ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_go && cpu_irq && !stk_full) |=> (stk_cnt == $past(stk_cnt) + 1'b1));
   // R8
   protect_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q && ivec_rd && !bus_wr) |=> $stable(stk_cnt));
endmodule

// File: tb/vnic_top_tb.sv
`timescale 1ns/1ps
module vnic_top_tb_top;
   localparam int NSRC = 32;
   localparam logic [31:0] SPV = 32'hDEAD_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cpu_irq, cpu_fiq, cpu_wake;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vnic_top #(.EXT_MASK(32'hE000_0001)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq),
      .cpu_wake(cpu_wake));

   function automatic logic [31:0] vec(int i);
      return 32'hA000_0000 + 32'(i * 4);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic line(int i, logic v);
      @(negedge clk); irq_in[i] = v;
      @(negedge clk);
   endtask

   task automatic pulse(int i);
      @(negedge clk); irq_in[i] = 1'b1;
      @(negedge clk); irq_in[i] = 1'b0;
      @(negedge clk);
   endtask

   // {lines, expected vector, expected irq, expected fiq}; all level-high, prio = i % 8
   localparam logic [65:0] TBL [0:7] = '{
      {32'h0000_0000, 32'hDEAD_0000, 1'b0, 1'b0},
      {32'h0000_0008, 32'hA000_000C, 1'b1, 1'b0},
      {32'h0000_0028, 32'hA000_0014, 1'b1, 1'b0},
      {32'h0000_8080, 32'hA000_001C, 1'b1, 1'b0},
      {32'h0000_0202, 32'hA000_0004, 1'b1, 1'b0},
      {32'h0001_0100, 32'hA000_0020, 1'b1, 1'b0},
      {32'h0000_0414, 32'hA000_0010, 1'b1, 1'b0},
      {32'h0000_0001, 32'hDEAD_0000, 1'b0, 1'b1}
   };

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check("R12 reset irq", 32'(cpu_irq), 0);
      check("R12 reset fiq", 32'(cpu_fiq), 0);
      check("R12 reset wake", 32'(cpu_wake), 0);
      rd(8'h42, d); check("R12 reset enables", d, 0);
      rd(8'h4B, d); check("R7 reset level", d, 0);

      for (int i = 0; i < NSRC; i++) begin
         wr(8'(i), 32'(i % 8));
         wr(8'(8'h20 + i), vec(i));
      end
      wr(8'h46, SPV);
      wr(8'h42, 32'hFFFF_FFFF);
      rd(8'h42, d); check("R12 enable readback", d, 32'hFFFF_FFFF);
      wr(8'h49, 32'h1);   // protect on: reads have no side effects

      for (int k = 0; k < 8; k++) begin
         @(negedge clk); irq_in = TBL[k][65:34];
         @(negedge clk);
         check($sformatf("R1 R2 table %0d irq", k), 32'(cpu_irq), 32'(TBL[k][1]));
         check($sformatf("R2 table %0d fiq", k), 32'(cpu_fiq), 32'(TBL[k][0]));
         rd(8'h40, d);
         check($sformatf("R1 R9 table %0d vector", k), d, TBL[k][33:2]);
      end
      @(negedge clk); irq_in = '0;
      wr(8'h49, 32'h0);
      rd(8'h4B, d); check("R8 no push during protected reads", d, 0);

      // R5 R6 R7 nesting
      line(3, 1'b1);
      check("R5 irq on empty stack", 32'(cpu_irq), 1);
      rd(8'h40, d); check("R6 first vector", d, vec(3));
      check("R5 same level blocked", 32'(cpu_irq), 0);
      rd(8'h4B, d); check("R6 level after push", d, 32'h103);
      line(5, 1'b1);
      check("R5 higher preempts", 32'(cpu_irq), 1);
      rd(8'h40, d); check("R6 nested vector", d, vec(5));
      rd(8'h4B, d); check("R6 level after nest", d, 32'h205);
      check("R5 blocked at top level", 32'(cpu_irq), 0);
      wr(8'h45, 0);
      rd(8'h4B, d); check("R7 pop restores", d, 32'h103);
      check("R5 level 5 above 3 again", 32'(cpu_irq), 1);
      line(5, 1'b0);
      check("R5 level 3 blocked", 32'(cpu_irq), 0);
      wr(8'h45, 0);
      check("R5 empty again", 32'(cpu_irq), 1);
      line(3, 1'b0);
      wr(8'h45, 0);
      rd(8'h4B, d); check("R7 pop when empty ignored", d, 0);

      // R4 R6 edge source
      wr(8'd12, 32'h24);
      pulse(12);
      check("R4 flag held after pulse", 32'(cpu_irq), 1);
      rd(8'h40, d); check("R6 edge vector", d, vec(12));
      check("R6 flag cleared by ack", 32'(cpu_irq), 0);
      rd(8'h4B, d); check("R6 edge push", d, 32'h104);
      wr(8'h45, 0);
      check("R4 no new flag", 32'(cpu_irq), 0);

      // R8 protect
      pulse(12);
      wr(8'h49, 32'h1);
      rd(8'h40, d); check("R8 protected vector", d, vec(12));
      check("R8 flag kept", 32'(cpu_irq), 1);
      rd(8'h4B, d); check("R8 no push on read", d, 0);
      wr(8'h40, 0);
      check("R8 write clears", 32'(cpu_irq), 0);
      rd(8'h4B, d); check("R8 write pushes", d, 32'h104);
      wr(8'h45, 0);
      wr(8'h49, 32'h0);

      // R9 spurious
      line(3, 1'b1);
      check("R9 irq raised", 32'(cpu_irq), 1);
      line(3, 1'b0);
      rd(8'h40, d); check("R9 spurious vector", d, SPV);
      rd(8'h4B, d); check("R9 no push", d, 0);

      // R3 trigger types
      wr(8'd30, 32'h66);
      line(30, 1'b1);
      check("R3 rising ignored for falling", 32'(cpu_irq), 0);
      line(30, 1'b0);
      check("R3 falling edge latched", 32'(cpu_irq), 1);
      rd(8'h40, d); check("R3 falling vector", d, vec(30));
      wr(8'h45, 0);
      wr(8'd20, 32'h66);
      line(20, 1'b1);
      check("R3 internal ignores invert", 32'(cpu_irq), 1);
      rd(8'h40, d); check("R3 internal vector", d, vec(20));
      wr(8'h45, 0);
      line(20, 1'b0);
      check("R3 no edge on fall", 32'(cpu_irq), 0);
      wr(8'd31, 32'h46);
      @(negedge clk);
      check("R3 low level pending", 32'(cpu_irq), 1);
      rd(8'h40, d); check("R3 low level vector", d, vec(31));
      line(31, 1'b1);
      wr(8'h45, 0);
      check("R3 high line idle", 32'(cpu_irq), 0);

      // R10 forcing
      wr(8'h47, 32'h40);
      line(6, 1'b1);
      check("R10 forced to fiq", 32'(cpu_fiq), 1);
      check("R10 forced not irq", 32'(cpu_irq), 0);
      rd(8'h40, d); check("R10 forced out of arbitration", d, SPV);
      line(6, 1'b0);
      check("R10 level forced drops", 32'(cpu_fiq), 0);
      wr(8'h47, 32'h1000);
      pulse(12);
      check("R10 forced edge fiq", 32'(cpu_fiq), 1);
      rd(8'h41, d); check("R2 fast vector", d, vec(0));
      check("R10 forced sticky", 32'(cpu_fiq), 1);
      wr(8'h44, 32'h1000);
      check("R10 cleared by write", 32'(cpu_fiq), 0);
      wr(8'h48, 32'h1040);
      rd(8'h47, d); check("R10 force released", d, 0);

      // R2 source 0
      line(0, 1'b1);
      check("R2 src0 fiq", 32'(cpu_fiq), 1);
      check("R2 src0 not irq", 32'(cpu_irq), 0);
      line(0, 1'b0);
      check("R2 src0 drops", 32'(cpu_fiq), 0);

      // R11 R12 mask and enables
      wr(8'h49, 32'h2);
      line(3, 1'b1);
      check("R11 mask irq", 32'(cpu_irq), 0);
      check("R11 mask fiq", 32'(cpu_fiq), 0);
      check("R11 wake", 32'(cpu_wake), 1);
      wr(8'h43, 32'h8);
      check("R12 disabled no wake", 32'(cpu_wake), 0);
      wr(8'h49, 32'h0);
      check("R12 disabled no irq", 32'(cpu_irq), 0);
      wr(8'h42, 32'h8);
      check("R12 re-enabled irq", 32'(cpu_irq), 1);
      line(3, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule